// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a periodic event source for a small 8-bit system clocked at 4.194304 MHz. A free-running 16-bit prescale chain advances on every clock. Its upper byte can be read as a coarse time base. One of four taps on the chain paces an 8-bit event counter. When the counter rolls past its top value, it does not return to zero. Instead it takes a software-chosen start value from a reload register, and a one-cycle interrupt request goes to the system's interrupt controller.

Software reaches four byte registers through a plain bus: a 2-bit address, write data, a write strobe and combinational read data. Writing the time-base register restarts the whole prescale chain from zero, whatever value is written. This gives software a known phase for the first event. The control register holds a run bit and a 2-bit rate code.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is low.
- R2: Register select: address 0 is the time base, 1 is the event counter, 2 is the reload value, and 3 is control. Control bits 2:0 read back as written and bits 7:3 read as zero. Reads are combinational.
- R3: The time base reads the upper 8 bits of a 16-bit prescale chain that advances on every clock, so it increments once every 256 cycles. A write to address 0 clears the whole chain to zero and ignores the data written.
- R4: Control bit 2 is the run bit. While it is 0, the event counter holds its value and `irq_o` stays low.
- R5: Control bits 1:0 select the tick period in clock cycles: code 0 gives 1024, code 1 gives 16, code 2 gives 64 and code 3 gives 256. After the chain is cleared at edge E0, ticks fall on edges E0+N, E0+2N, and so on.
- R6: Each tick below 0xFF increments the event counter by one.
- R7: A tick while the counter holds 0xFF loads the counter from the reload register, including a reload value of 0xFF.
- R8: `irq_o` is high for exactly one cycle, and that cycle is the one in which the reloaded value first appears on the counter.
- R9: A bus write to the counter on the same edge as a tick takes priority. The written value is stored unchanged and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Overflow interrupt request pulse |

## Verification
A bus write takes effect at the edge that samples the strobe, and a read reflects the register state in the same cycle. After the chain is cleared at edge E0, the counter changes exactly at edges E0+kN, and `irq_o` rises together with the reloaded value in the cycle after that edge. The bench counts rising edges from the clearing write and samples at the following falling edge. It compares every cycle of a sweep over all four rate codes, with several reload values, against an arithmetic model of those edges. The time-base and write-priority checks are placed on the exact edges before and after each due change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_TBASE  = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RATE_SLOWEST = 2'd0,
        RATE_FASTEST = 2'd1,
        RATE_FAST    = 2'd2,
        RATE_SLOW    = 2'd3
    } rate_e;

    typedef struct packed {
        logic  run;
        rate_e rate;
    } ctrl_t;

    localparam int RATE_CODES = 4;
    localparam int CTRL_W     = 3;

    // log2 of the tick period for a rate code (the code order is behaviour)
    function automatic int rate_log2(input logic [1:0] code);
        case (code)
            2'd0:    rate_log2 = 10;
            2'd1:    rate_log2 = 4;
            2'd2:    rate_log2 = 6;
            default: rate_log2 = 8;
        endcase
    endfunction

endpackage

// File: rtl/tmr_div_chain.sv
module tmr_div_chain #(
    parameter int CHAIN_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    output logic [CHAIN_W-1:0] chain_o
);

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q + {{(CHAIN_W-1){1'b0}}, 1'b1};
        if (clr_i) chain_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign chain_o = chain_q;

    // R3: a clearing write leaves the chain at zero on the next cycle
    assert_chain_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (chain_o == '0));

endmodule

// File: rtl/tmr_rate_pick.sv
module tmr_rate_pick #(
    parameter int CHAIN_W = 16
) (
    input  logic [CHAIN_W-1:0] chain_i,
    input  logic               run_i,
    input  tmr_pkg::rate_e     rate_i,
    output logic               tick_o
);
    import tmr_pkg::*;

    logic [RATE_CODES-1:0] hit;

    // one terminal-count detector per rate code
    for (genvar i = 0; i < RATE_CODES; i++) begin : g_tap
        localparam int L = rate_log2(2'(i));
        assign hit[i] = &chain_i[L-1:0];
    end

    always_comb begin
        tick_o = run_i & hit[rate_i];
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         cnt_we_i,
    input  logic         rld_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic         irq;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (rld_we_i) st_d.rld = wdata_i;
        if (cnt_we_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i) begin
            if (&st_q.cnt) begin
                st_d.cnt = st_q.rld;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + {{(W-1){1'b0}}, 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign rld_o = st_q.rld;
    assign irq_o = st_q.irq;

    // R8: the request never lasts beyond one cycle
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7: when the request is up, the counter shows the reload value from before the edge
    assert_irq_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !cnt_we_i && (&cnt_o) |=> irq_o && (cnt_o == $past(rld_o)));

    // R9: a counter write wins over any tick and raises no request
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (cnt_o == $past(wdata_i)) && !irq_o);

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer #(
    parameter int CHAIN_W = 16,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    import tmr_pkg::*;

    localparam int PAD_W = DATA_W - CTRL_W;

    ctrl_t ctrl_d, ctrl_q;
    logic [CHAIN_W-1:0] chain;
    logic [DATA_W-1:0]  cnt, rld;
    logic               tick;
    logic               we_tbase, we_count, we_reload, we_ctrl;

    always_comb begin
        we_tbase  = reg_we && (reg_sel_e'(reg_addr) == SEL_TBASE);
        we_count  = reg_we && (reg_sel_e'(reg_addr) == SEL_COUNT);
        we_reload = reg_we && (reg_sel_e'(reg_addr) == SEL_RELOAD);
        we_ctrl   = reg_we && (reg_sel_e'(reg_addr) == SEL_CTRL);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_ctrl) begin
            ctrl_d.run  = reg_wdata[2];
            ctrl_d.rate = rate_e'(reg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tmr_div_chain #(.CHAIN_W(CHAIN_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (we_tbase),
        .chain_o (chain)
    );

    tmr_rate_pick #(.CHAIN_W(CHAIN_W)) pick_i (
        .chain_i (chain),
        .run_i   (ctrl_q.run),
        .rate_i  (ctrl_q.rate),
        .tick_o  (tick)
    );

    tmr_count_core #(.W(DATA_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .cnt_we_i (we_count),
        .rld_we_i (we_reload),
        .wdata_i  (reg_wdata),
        .cnt_o    (cnt),
        .rld_o    (rld),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_TBASE:  reg_rdata = chain[CHAIN_W-1 -: DATA_W];
            SEL_COUNT:  reg_rdata = cnt;
            SEL_RELOAD: reg_rdata = rld;
            default:    reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
        endcase
    end

    // R4: a stopped timer with no counter write keeps its count
    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !we_count) |=> (cnt == $past(cnt)));

    // R4: a request only follows a cycle in which the timer was running
    assert_irq_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctrl_q.run));

endmodule

// File: tb/prog_interval_timer_tb_top.sv
module prog_interval_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    int e0 = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    prog_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at edge %0d", req, act, exp, edge_n);
        end
    endtask

    // tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_chain();
        wr(2'd0, 8'hA5);
        e0 = edge_n;
    endtask

    task automatic wait_k(input int k);
        while (edge_n - e0 < k) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            if (a == 0) chk("R1 tbase", int'(v), 0);
            else        chk("R1 reg", int'(v), 0);
        end
        chk("R1 irq", int'(irq_o), 0);

        // R2: register readback
        wr(2'd3, 8'hFB); rd(2'd3, v); chk("R2 ctrl mask", int'(v), 8'h03);
        wr(2'd2, 8'h5C); rd(2'd2, v); chk("R2 reload", int'(v), 8'h5C);
        wr(2'd1, 8'h21); rd(2'd1, v); chk("R2 count", int'(v), 8'h21);

        // R3: time base clear and pace
        clear_chain();
        rd(2'd0, v); chk("R3 cleared", int'(v), 0);
        for (int j = 1; j <= 3; j++) begin
            wait_k(256 * j - 1); rd(2'd0, v); chk("R3 before step", int'(v), j - 1);
            wait_k(256 * j);     rd(2'd0, v); chk("R3 after step", int'(v), j);
        end

        // R4: stopped timer holds, at the fastest rate code
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h01);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(2'd1, v);
            if (v != 8'hFF || irq_o) chk("R4 hold", int'({irq_o, v}), 8'hFF);
        end
        chk("R4 held", int'(v), 8'hFF);

        // R5 R6 R7 R8: sweep every rate code with several reload values
        for (int c = 0; c < 4; c++) begin
            int n;
            logic [7:0] m, mv;
            logic ei;
            n = (c == 0) ? 1024 : (c == 1) ? 16 : (c == 2) ? 64 : 256;
            m = (c == 0) ? 8'h37 : (c == 1) ? 8'hFF : (c == 2) ? 8'h00 : 8'h80;
            wr(2'd3, 8'h00);
            wr(2'd1, 8'hFD);
            wr(2'd2, m);
            clear_chain();
            wr(2'd3, 8'(4 + c));
            mv = 8'hFD;
            reg_addr = 2'd1;
            for (int k = 2; k <= 5 * n; k++) begin
                wait_k(k);
                ei = 1'b0;
                if (k % n == 0) begin
                    if (mv == 8'hFF) begin mv = m; ei = 1'b1; end
                    else mv = mv + 8'd1;
                end
                #1;
                if (ei) chk("R7 reload value", int'(reg_rdata), int'(mv));
                else if (k % n == 0) chk("R6 increment", int'(reg_rdata), int'(mv));
                else chk("R5 between ticks", int'(reg_rdata), int'(mv));
                chk("R8 irq", int'(irq_o), int'(ei));
            end
        end

        // R9: counter write on a tick edge wins
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h00);
        clear_chain();
        wr(2'd3, 8'h05);
        wait_k(15);
        rd(2'd1, v); chk("R9 before", int'(v), 8'h10);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R9 write wins", int'(v), 8'hFF);
        chk("R9 no irq", int'(irq_o), 0);
        wait_k(31); rd(2'd1, v); chk("R9 hold", int'(v), 8'hFF);
        wait_k(32); rd(2'd1, v); chk("R9 then reload", int'(v), 0);
        chk("R8 irq after", int'(irq_o), 1);
        wait_k(33); chk("R8 irq drop", int'(irq_o), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule